// File: doc/BRIEF.md
# Programmable Skew Clock Bank Generator

This block derives eight clock lines, grouped as four banks of two, from a fast tick clock. One nominal output period is made of N ticks, and one tick is the time unit. Each bank has a pair of three-level selects. The select pair either shifts the bank's 50% duty waveform by a signed number of time units, or it picks a divided or inverted form of the nominal clock. Banks A and B move in single units. Banks C and D move in steps of two units, and they also provide the divide and invert functions. A range select sets N.

In normal mode the outputs are built from an internal period counter. When the bypass select is not LOW, the outputs follow a reference clock input. That input passes through a synchronizer and a tapped delay line, so the relative spacing of the banks is still set by the bank selects. Select and range changes are taken only at the end of a period.

Top module: `skew_clk_gen`

## Requirements
- R1: Both lines of a bank always carry the same level.
- R2: Each three-level input is two bits: 00 = LOW, 01 = MID, 10 = HIGH, 11 = MID. Bank selects are {sel1, sel0}. For banks A and B, the select pairs LL, LM, LH, ML, MM, MH, HL, HM and HH give offsets k of −4, −3, −2, −1, 0, +1, +2, +3 and +4 units.
- R3: For banks C and D, the select pairs LM, LH, ML, MM, MH, HL and HM give offsets of −6, −4, −2, 0, +2, +4 and +6 units.
- R4: For banks C and D, LL gives the nominal clock divided by 2. HH gives the nominal clock divided by 4 on bank C and the inverted nominal clock on bank D. Periods are counted from 0 after reset. A divided-by-2 output is high during even periods. A divided-by-4 output is high during periods 0 and 1 modulo 4. Divided outputs therefore rise together with the 0-unit waveform.
- R5: The period length N is 44 ticks for range LOW, 26 for MID (and code 11) and 16 for HIGH.
- R6: Let c be the period counter value (0..N−1). In normal mode, the output of a bank with offset k is high in the cycle after the counter holds c exactly when (c−k) mod N < N/2. This gives 50% duty and a 0-unit rising edge at the period start, and a negative offset wraps into the previous period.
- R7: During reset all outputs are low. After release, the first period uses N = 44 and offset 0 on every bank, whatever the inputs are.
- R8: Bank selects and range are sampled only in the last tick of a period. A change in mid-period has no effect until the next period starts.
- R9: If the bypass select is MID or HIGH, a bank with offset k equals the reference input level applied 10+k cycles earlier. An inverted bank D equals the complement of the level applied 10 cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one time unit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_sel_i | input | 2 | Three-level range select setting N |
| bypass_sel_i | input | 2 | Three-level bypass select, LOW = normal |
| ref_clk_i | input | 1 | Reference clock used in bypass mode |
| sel_a_i | input | 4 | Bank A select pair {sel1, sel0} |
| sel_b_i | input | 4 | Bank B select pair |
| sel_c_i | input | 4 | Bank C select pair |
| sel_d_i | input | 4 | Bank D select pair |
| q_a_o | output | 2 | Bank A clock lines |
| q_b_o | output | 2 | Bank B clock lines |
| q_c_o | output | 2 | Bank C clock lines |
| q_d_o | output | 2 | Bank D clock lines |

## Verification
Tick p counts the clock edges after reset release, starting at 1. The output after edge p reflects a counter value of p−1 in the first period. A configuration sampled at edge 44 governs the outputs from edge 45 on. The bench keeps a tick index for each edge and compares every tick against the value these rules give, so the default first period and the start of each new period are both checked exactly. In bypass, the bench logs the reference level it drove at each falling edge. It compares each bank with the entry 10+k falling edges older. That lag covers two synchronizer stages, the tap position and the output register.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {MD_SHIFT, MD_DIV2, MD_DIV4, MD_INV} mode_e;

  typedef struct packed {
    mode_e             mode;
    logic signed [3:0] off;
  } bank_cfg_t;

  localparam int KIND_FINE = 0;
  localparam int KIND_WIDE_DIV4 = 1;
  localparam int KIND_WIDE_INV = 2;

  // 00 low, 01 mid, 10 high, 11 treated as open (mid)
  function automatic int lvl_idx(logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic bank_cfg_t decode_sel(int kind, logic [3:0] sel);
    bank_cfg_t r;
    int i;
    i = 3 * lvl_idx(sel[3:2]) + lvl_idx(sel[1:0]);
    r.mode = MD_SHIFT;
    r.off  = '0;
    if (kind == KIND_FINE) r.off = 4'(i - 4);
    else if (i == 0) r.mode = MD_DIV2;
    else if (i == 8) r.mode = (kind == KIND_WIDE_DIV4) ? MD_DIV4 : MD_INV;
    else r.off = 4'(2 * (i - 4));
    return r;
  endfunction
endpackage

// File: rtl/skew_period_ctr.sv
module skew_period_ctr #(
  parameter int N_LO  = 44,
  parameter int N_MID = 26,
  parameter int N_HI  = 16,
  parameter int NB    = 4,
  localparam int CW   = $clog2(N_LO + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            range_i,
  input  logic [NB-1:0][3:0]    sel_i,
  output logic [CW-1:0]         cnt_o,
  output logic [CW-1:0]         n_o,
  output logic [1:0]            pidx_o,
  output logic [NB-1:0][3:0]    sel_q_o
);
  import skew_pkg::*;

  logic [CW-1:0]      cnt, n_cur, n_next;
  logic [1:0]         pidx;
  logic [NB-1:0][3:0] sel_q;
  logic               wrap;

  assign wrap = (cnt == n_cur - CW'(1));

  always_comb begin
    case (lvl_idx(range_i))
      0:       n_next = CW'(N_LO);
      1:       n_next = CW'(N_MID);
      default: n_next = CW'(N_HI);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      pidx  <= '0;
      n_cur <= CW'(N_LO);
      sel_q <= {NB{4'b0101}};
    end else if (wrap) begin
      cnt   <= '0;
      pidx  <= pidx + 2'd1;
      n_cur <= n_next;
      sel_q <= sel_i;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign cnt_o   = cnt;
  assign n_o     = n_cur;
  assign pidx_o  = pidx;
  assign sel_q_o = sel_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < n_cur);

  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt == '0));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ($stable(sel_q) && $stable(n_cur)));
endmodule

// File: rtl/skew_ref_line.sv
module skew_ref_line #(
  parameter int MAX_OFF = 6,
  localparam int HL     = 2 * MAX_OFF + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_i,
  output logic [HL-1:0] hist_o,
  output logic [1:0]    div_o
);
  logic          s1, s2;
  logic [HL-1:0] hist;
  logic [1:0]    div_cnt;
  logic          rise;

  // rising edge seen at the zero-offset tap
  assign rise = hist[MAX_OFF] & ~hist[MAX_OFF+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      hist    <= '0;
      div_cnt <= '0;
    end else begin
      s1   <= ref_i;
      s2   <= s1;
      hist <= {hist[HL-2:0], s2};
      if (rise) div_cnt <= div_cnt + 2'd1;
    end
  end

  assign hist_o = hist;
  assign div_o  = ~div_cnt;
endmodule

// File: rtl/skew_bank.sv
module skew_bank #(
  parameter int KIND    = 0,
  parameter int MAX_OFF = 6,
  parameter int CW      = 6,
  localparam int HL     = 2 * MAX_OFF + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byp_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] n_i,
  input  logic [1:0]    pidx_i,
  input  logic [3:0]    sel_i,
  input  logic [HL-1:0] hist_i,
  input  logic [1:0]    bp_div_i,
  output logic [1:0]    q_o
);
  import skew_pkg::*;

  bank_cfg_t cfg;
  logic      nom, bp, tap_off, tap_zero, out_q;
  int        c, n, k, ph;

  always_comb begin
    cfg = decode_sel(KIND, sel_i);
    c   = int'(cnt_i);
    n   = int'(n_i);
    k   = int'(cfg.off);
    ph  = c - k + n;
    if (ph >= 2 * n) ph = ph - 2 * n;
    else if (ph >= n) ph = ph - n;
    tap_off  = 1'b0;
    tap_zero = hist_i[MAX_OFF];
    for (int j = 0; j < HL; j++)
      if (j == MAX_OFF + k) tap_off = hist_i[j];
    case (cfg.mode)
      MD_DIV2: begin nom = ~pidx_i[0];      bp = bp_div_i[0]; end
      MD_DIV4: begin nom = ~pidx_i[1];      bp = bp_div_i[1]; end
      MD_INV:  begin nom = !(c < n / 2);    bp = ~tap_zero;   end
      default: begin nom = (ph < n / 2);    bp = tap_off;     end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= byp_i ? bp : nom;
  end

  assign q_o = {2{out_q}};

  p_div_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && !$past(byp_i) && !$past(byp_i, 2) && cfg.mode == MD_DIV2 &&
     $past(cfg.mode) == MD_DIV2 && out_q != $past(out_q)) |-> ($past(cnt_i) == '0));
endmodule

// File: rtl/skew_clk_gen.sv
module skew_clk_gen #(
  parameter int N_LO    = 44,
  parameter int N_MID   = 26,
  parameter int N_HI    = 16,
  parameter int MAX_OFF = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] range_sel_i,
  input  logic [1:0] bypass_sel_i,
  input  logic       ref_clk_i,
  input  logic [3:0] sel_a_i,
  input  logic [3:0] sel_b_i,
  input  logic [3:0] sel_c_i,
  input  logic [3:0] sel_d_i,
  output logic [1:0] q_a_o,
  output logic [1:0] q_b_o,
  output logic [1:0] q_c_o,
  output logic [1:0] q_d_o
);
  import skew_pkg::*;

  localparam int NB = 4;
  localparam int CW = $clog2(N_LO + 1);
  localparam int HL = 2 * MAX_OFF + 1;

  logic [NB-1:0][3:0] sel_in, sel_q;
  logic [CW-1:0]      cnt, n_cur;
  logic [1:0]         pidx;
  logic [HL-1:0]      hist;
  logic [1:0]         bp_div;
  logic               byp_q;
  logic [NB-1:0][1:0] q_all;

  assign sel_in = {sel_d_i, sel_c_i, sel_b_i, sel_a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= (lvl_idx(bypass_sel_i) != 0);
  end

  skew_period_ctr #(.N_LO(N_LO), .N_MID(N_MID), .N_HI(N_HI), .NB(NB)) i_ctr (
    .clk_i, .rst_ni, .range_i(range_sel_i), .sel_i(sel_in),
    .cnt_o(cnt), .n_o(n_cur), .pidx_o(pidx), .sel_q_o(sel_q)
  );

  skew_ref_line #(.MAX_OFF(MAX_OFF)) i_ref (
    .clk_i, .rst_ni, .ref_i(ref_clk_i), .hist_o(hist), .div_o(bp_div)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    localparam int KIND = (g < 2) ? KIND_FINE : (g == 2) ? KIND_WIDE_DIV4 : KIND_WIDE_INV;
    skew_bank #(.KIND(KIND), .MAX_OFF(MAX_OFF), .CW(CW)) i_bank (
      .clk_i, .rst_ni, .byp_i(byp_q), .cnt_i(cnt), .n_i(n_cur), .pidx_i(pidx),
      .sel_i(sel_q[g]), .hist_i(hist), .bp_div_i(bp_div), .q_o(q_all[g])
    );
  end

  assign q_a_o = q_all[0];
  assign q_b_o = q_all[1];
  assign q_c_o = q_all[2];
  assign q_d_o = q_all[3];
endmodule

// File: tb/test_skew_clk_gen.sv
module test_skew_clk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] range_sel_i = 2'b00, bypass_sel_i = 2'b00;
  logic       ref_clk_i = 1'b0;
  logic [3:0] sel_a_i = 4'b0101, sel_b_i = 4'b0101, sel_c_i = 4'b0101, sel_d_i = 4'b0101;
  logic [1:0] q_a_o, q_b_o, q_c_o, q_d_o;

  int errs = 0, checks = 0;
  bit ref_log [0:511];

  always #2ns clk_i = ~clk_i;

  skew_clk_gen i_skew_clk_gen (.*);

  // {exp_n, range, a, b, c, d}
  localparam logic [23:0] VECS [6] = '{
    {6'd16, 2'b10, 4'b0000, 4'b1010, 4'b0000, 4'b1010},
    {6'd26, 2'b01, 4'b0001, 4'b0110, 4'b1010, 4'b0001},
    {6'd44, 2'b00, 4'b0100, 4'b1000, 4'b1001, 4'b0010},
    {6'd26, 2'b11, 4'b1111, 4'b1001, 4'b0110, 4'b0100},
    {6'd16, 2'b10, 4'b0010, 4'b0101, 4'b1000, 4'b0000},
    {6'd16, 2'b10, 4'b1010, 4'b0000, 4'b0001, 4'b1001}
  };
  localparam string VTAG [6] = '{"R6", "R5", "R5", "R5", "R6", "R6"};

  function automatic int lvl(logic [1:0] v);
    return (v == 2'b00) ? 0 : (v == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic exp_level(int b, logic [3:0] s, int c, int q, int n);
    int i, k, ph;
    i = 3 * lvl(s[3:2]) + lvl(s[1:0]);
    if (b < 2) k = i - 4;
    else if (i == 0) return (q % 2) == 0;
    else if (i == 8) return (b == 2) ? ((q % 4) < 2) : !(c < n / 2);
    else k = 2 * (i - 4);
    ph = ((c - k) % n + n) % n;
    return ph < n / 2;
  endfunction

  function automatic logic [1:0] bank_out(int b);
    case (b)
      0: return q_a_o;
      1: return q_b_o;
      2: return q_c_o;
      default: return q_d_o;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int p, input int b,
                     input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s tick=%0d bank=%0d got=%b exp=%b", tag, p, b, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] rng, input logic [1:0] byp,
                          input logic [3:0] sa, sb, sc, sd);
    @(negedge clk_i);
    rst_ni = 1'b0;
    range_sel_i = rng; bypass_sel_i = byp;
    sel_a_i = sa; sel_b_i = sb; sel_c_i = sc; sel_d_i = sd;
    ref_clk_i = 1'b0;
    repeat (2) @(negedge clk_i);
    for (int b = 0; b < 4; b++) chk(bank_out(b) == 2'b00, "R7", 0, b, bank_out(b), 2'b00);
    rst_ni = 1'b1;
  endtask

  task automatic run_norm(input logic [1:0] rng, input logic [3:0] sa, sb, sc, sd,
                          input int n, input string atag, input logic [3:0] sa_new,
                          input int sw_p);
    logic [3:0] sel [4];
    sel[0] = sa; sel[1] = sb; sel[2] = sc; sel[3] = sd;
    do_reset(rng, 2'b00, sa, sb, sc, sd);
    for (int p = 1; p <= 44 + 5 * n; p++) begin
      @(negedge clk_i);
      for (int b = 0; b < 4; b++) begin
        int c, q, nn, t;
        logic [3:0] s;
        logic e;
        string tag;
        if (p <= 44) begin
          c = p - 1; q = 0; nn = 44; s = 4'b0101; tag = "R7";
        end else begin
          t = p - 45; c = t % n; q = 1 + t / n; nn = n; s = sel[b];
          if (b == 0) begin
            tag = atag;
            if (44 + n * (t / n) > sw_p) s = sa_new;
            if (sw_p < 1000) tag = "R8";
          end else if (b == 1) tag = "R2";
          else if (lvl(s[3:2]) * 3 + lvl(s[1:0]) inside {0, 8}) tag = "R4";
          else tag = "R3";
        end
        e = exp_level(b, s, c, q, nn);
        chk(bank_out(b) == {e, e}, tag, p, b, bank_out(b), {e, e});
        if (p == 45) chk(bank_out(b)[0] == bank_out(b)[1], "R1", p, b, bank_out(b), {2{bank_out(b)[0]}});
      end
      if (p == sw_p) sel_a_i = sa_new;
    end
  endtask

  task automatic run_byp(input logic [1:0] bsel, input logic [3:0] sa, sb, sc, sd,
                         input int la, lb, lc, ld, input bit inv_d);
    int lag [4];
    lag[0] = la; lag[1] = lb; lag[2] = lc; lag[3] = ld;
    do_reset(2'b10, bsel, sa, sb, sc, sd);
    for (int m = 1; m <= 200; m++) begin
      @(negedge clk_i);
      if (m >= 80) begin
        for (int b = 0; b < 4; b++) begin
          logic e;
          e = ref_log[m - lag[b]];
          if (b == 3 && inv_d) e = ~e;
          chk(bank_out(b) == {e, e}, "R9", m, b, bank_out(b), {e, e});
        end
      end
      ref_clk_i = ((m / 7) % 2) == 1;
      ref_log[m] = ref_clk_i;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL R7 watchdog got=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int v = 0; v < 6; v++)
      run_norm(VECS[v][17:16], VECS[v][15:12], VECS[v][11:8], VECS[v][7:4], VECS[v][3:0],
               int'(VECS[v][23:18]), VTAG[v], VECS[v][15:12], 100000);
    // mid-period change on bank A must wait for the next boundary
    run_norm(2'b10, 4'b0000, 4'b0101, 4'b0101, 4'b0101, 16, "R8", 4'b1010, 50);
    // bypass, MID code: offsets -4, +4, -6 and inverted D
    run_byp(2'b01, 4'b0000, 4'b1010, 4'b0001, 4'b1010, 6, 14, 4, 10, 1'b1);
    // bypass, HIGH code: offsets 0, -3, +6, +2
    run_byp(2'b10, 4'b0101, 4'b0001, 4'b1001, 4'b0110, 10, 7, 16, 12, 1'b0);
    summary();
    $finish;
  end
endmodule